// File: doc/BRIEF.md
# Single-Line Configurable Interrupt Controller

This block watches one external interrupt line, for example a non-maskable interrupt pin, and turns it into a processor interrupt. The raw line first passes through a synchronizer. A detector then looks for either an active level or an active edge, as chosen by a 2-bit trigger code. A detected event latches a pending flag. The interrupt output is a registered copy of pending AND enable.

Software reaches three registers through a single-cycle, word-wide register port. The port has a byte address, a write strobe, write data and combinational read data. A typical service routine first masks the output and acknowledges pending. It then handles the event and unmasks again. Any event that arrives while the output is masked stays latched, so it is not lost. A build-time parameter places the enable register at one of two offsets.

Top module: `irq_line_ctrl`

## Requirements
- R1: The line passes through two synchronizing flops. A change on the line sets pending at the third rising clock edge after it is first sampled, and not earlier.
- R2: The trigger code in the control register (offset 0x00, bits 1:0) has four values. 0 = line low is active. 1 = falling edge. 2 = line high is active. 3 = rising edge.
- R3: In a level mode, pending stays set after a write-1 acknowledge as long as the active level persists.
- R4: In an edge mode, pending sets only on the selected edge and holds until it is acknowledged. The opposite edge, or a line that stays steady, leaves pending at 0.
- R5: Pending reads in bit 0 of offset 0x04. Writing 1 to that bit clears pending. Writing 0 there has no effect.
- R6: The interrupt output is registered. It equals the pending AND enable values of the previous cycle, so it lags each of them by one clock.
- R7: The enable bit is bit 0 of offset 0x08 when ENA_ALT is 0, and bit 0 of offset 0x34 when ENA_ALT is 1. The other offset is then unmapped.
- R8: Register reads return zeros above the defined field bits. The control register reads back only its 2-bit code.
- R9: After reset, trigger code is 0, enable is 0, pending is 0 and the output is 0. The synchronizer holds the idle-high level.
- R10: Changing between the two edge codes while the line is steady does not set pending.
- R11: Reads of unmapped offsets return 0. Writes to unmapped offsets change no register.
- R12: When an event is detected in the same cycle as a write-1 acknowledge, the event wins and pending stays 1.
- R13: Suppose software masks the output, acknowledges pending, and an event arrives before it unmasks. Then the output rises once enable is set again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Raw external interrupt line, asynchronous |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
Two functions can fall on the same clock edge: detecting an edge event, and applying a write-1 acknowledge to pending. The bench provokes this in rising-edge mode. It first leaves pending already set. It then raises the line and times the acknowledge write so that it lands exactly on the edge where the synchronized edge is detected. The expected result is that pending still reads 1 afterwards. An acknowledge issued alone, in a quiet cycle, serves as the control case and must read 0.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        TRIG_LVL_LO    = 2'd0,
        TRIG_EDGE_FALL = 2'd1,
        TRIG_LVL_HI    = 2'd2,
        TRIG_EDGE_RISE = 2'd3
    } trig_e;

    localparam int unsigned REG_W = 32;

    typedef struct packed {
        trig_e mode;
        logic  enable;
        logic  pending;
        logic  irq;
    } ctl_state_t;

    function automatic logic is_edge_mode(trig_e m);
        return m[0];
    endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];

    // R1
    sync_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_o) |-> $past(chain_q[STAGES-2]));
endmodule

// File: rtl/irqc_detect.sv
module irqc_detect
    import irqc_pkg::*;
#(
    parameter logic RESET_VAL = 1'b1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sample_i,
    input  trig_e mode_i,
    output logic  hit_o
);
    logic hist_d, hist_q;

    always_comb begin
        hist_d = sample_i;
        unique case (mode_i)
            TRIG_LVL_LO:    hit_o = ~sample_i;
            TRIG_EDGE_FALL: hit_o = hist_q & ~sample_i;
            TRIG_LVL_HI:    hit_o = sample_i;
            TRIG_EDGE_RISE: hit_o = sample_i & ~hist_q;
            default:        hit_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= RESET_VAL;
        else        hist_q <= hist_d;
    end

    // R4
    edge_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_edge_mode(mode_i) && hit_o) |-> (sample_i != hist_q));

    // R10
    steady_no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(sample_i) && is_edge_mode(mode_i)) |-> !hit_o);
endmodule

// File: rtl/irq_line_ctrl.sv
module irq_line_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter bit          ENA_ALT     = 1'b0,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic        IDLE_LEVEL  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(8'h00);
    localparam logic [ADDR_W-1:0] PEND_OFS = ADDR_W'(8'h04);
    localparam logic [ADDR_W-1:0] ENA_OFS  = ENA_ALT ? ADDR_W'(8'h34) : ADDR_W'(8'h08);

    ctl_state_t st_d, st_q;
    logic       smp;
    logic       det_hit;
    logic       hit_ctrl, hit_pend, hit_ena, hit_none;
    logic       wdata_unused;

    assign wdata_unused = ^bus_wdata[31:2];

    irqc_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (IDLE_LEVEL)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (line_i),
        .sync_o  (smp)
    );

    irqc_detect #(
        .RESET_VAL (IDLE_LEVEL)
    ) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (smp),
        .mode_i   (st_q.mode),
        .hit_o    (det_hit)
    );

    always_comb begin
        hit_ctrl = (bus_addr == CTRL_OFS);
        hit_pend = (bus_addr == PEND_OFS);
        hit_ena  = (bus_addr == ENA_OFS);
        hit_none = !(hit_ctrl || hit_pend || hit_ena);
    end

    always_comb begin
        st_d = st_q;
        if (bus_we) begin
            if (hit_ctrl)                    st_d.mode    = trig_e'(bus_wdata[1:0]);
            if (hit_pend && bus_wdata[0])    st_d.pending = 1'b0;
            if (hit_ena)                     st_d.enable  = bus_wdata[0];
        end
        if (det_hit) st_d.pending = 1'b1;
        st_d.irq = st_q.pending & st_q.enable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: TRIG_LVL_LO, enable: 1'b0, pending: 1'b0, irq: 1'b0};
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl)      bus_rdata[1:0] = st_q.mode;
        else if (hit_pend) bus_rdata[0]   = st_q.pending;
        else if (hit_ena)  bus_rdata[0]   = st_q.enable;
    end

    assign irq_o = st_q.irq;

    // R6
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pending && st_q.enable) |=> irq_o);

    // R6
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.enable |=> !irq_o);

    // R5
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit_pend && bus_wdata[0] && !det_hit) |=> !st_q.pending);

    // R12
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        det_hit |=> st_q.pending);

    // R11
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit_none) |=> ($stable(st_q.mode) && $stable(st_q.enable)));

    // R8
    rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:2] == 30'd0);
endmodule

// File: tb/tb_irq_line_ctrl.sv
`timescale 1ns/1ps
module tb_irq_line_ctrl;

    typedef struct {
        logic [31:0] rd;
        logic        irq;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_r = 1'b1;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] rd_main, rd_alt;
    logic        irq_main, irq_alt;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sbq[$];
    exp_t cur;

    always #2 clk = ~clk;

    irq_line_ctrl #(.ADDR_W(8), .ENA_ALT(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .line_i(line_r), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(rd_main), .irq_o(irq_main)
    );

    irq_line_ctrl #(.ADDR_W(8), .ENA_ALT(1'b1)) dut_alt (
        .clk(clk), .rst_n(rst_n), .line_i(line_r), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(rd_alt), .irq_o(irq_alt)
    );

    // monitor: pops expected items and compares against the design
    always @(negedge clk) begin
        #1;
        if (sbq.size() > 0) begin
            cur = sbq.pop_front();
            checks++;
            if (rd_main !== cur.rd || irq_main !== cur.irq) begin
                errors++;
                $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                         cur.tag, rd_main, irq_main, cur.rd, cur.irq);
            end
        end
    end

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] rd,
                             input logic irq, input string tag);
        exp_t it;
        @(negedge clk);
        bus_addr = a;
        bus_we   = 1'b0;
        it.rd  = rd;
        it.irq = irq;
        it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic set_line(input logic v);
        @(negedge clk);
        line_r = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic chk_alt(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R9 reset values while reset is held
        expect_rd(8'h00, 32'h0, 1'b0, "R9 ctrl at reset");
        expect_rd(8'h04, 32'h0, 1'b0, "R9 pending at reset");
        expect_rd(8'h08, 32'h0, 1'b0, "R9 enable at reset");
        @(negedge clk);
        rst_n = 1'b1;
        idle(4);
        expect_rd(8'h04, 32'h0, 1'b0, "R9 no pending after reset with idle line");

        // R8 control keeps two bits
        wr(8'h00, 32'hFFFF_FFFF);
        expect_rd(8'h00, 32'h3, 1'b0, "R8 ctrl readback");
        // R10 switch edge modes on steady line
        wr(8'h00, 32'h1);
        idle(3);
        expect_rd(8'h04, 32'h0, 1'b0, "R10 mode change no pending");

        // R1 falling edge timing through synchronizer
        set_line(1'b0);
        expect_rd(8'h04, 32'h0, 1'b0, "R1 edge+1");
        expect_rd(8'h04, 32'h0, 1'b0, "R1 edge+2");
        expect_rd(8'h04, 32'h1, 1'b0, "R1 R2 falling sets at edge+3");
        set_line(1'b1);
        idle(4);
        expect_rd(8'h04, 32'h1, 1'b0, "R4 edge pending holds");
        wr(8'h04, 32'h1);
        idle(2);
        expect_rd(8'h04, 32'h0, 1'b0, "R5 write-1 clears");
        set_line(1'b0);
        idle(4);
        wr(8'h04, 32'h1);
        set_line(1'b1);
        idle(4);
        expect_rd(8'h04, 32'h0, 1'b0, "R4 rising ignored in falling mode");

        // rising edge mode
        wr(8'h00, 32'h3);
        set_line(1'b0);
        idle(4);
        expect_rd(8'h04, 32'h0, 1'b0, "R4 falling ignored in rising mode");
        set_line(1'b1);
        idle(4);
        expect_rd(8'h04, 32'h1, 1'b0, "R2 rising sets");
        wr(8'h04, 32'h0);
        idle(2);
        expect_rd(8'h04, 32'h1, 1'b0, "R5 write-0 no effect");
        wr(8'h04, 32'h1);
        idle(2);
        expect_rd(8'h04, 32'h0, 1'b0, "R4 high line no retrigger");

        // R12 event and acknowledge on the same edge
        set_line(1'b0);
        idle(4);
        set_line(1'b1);
        idle(4);
        set_line(1'b0);
        idle(4);
        set_line(1'b1);
        @(negedge clk);
        @(negedge clk);
        bus_addr  = 8'h04;
        bus_wdata = 32'h1;
        bus_we    = 1'b1;
        @(posedge clk);
        #1 bus_we = 1'b0;
        expect_rd(8'h04, 32'h1, 1'b0, "R12 event wins over ack");
        wr(8'h04, 32'h1);
        idle(2);
        expect_rd(8'h04, 32'h0, 1'b0, "R12 control ack alone");

        // level high
        wr(8'h00, 32'h2);
        idle(4);
        expect_rd(8'h04, 32'h1, 1'b0, "R2 high level sets");
        wr(8'h04, 32'h1);
        idle(1);
        expect_rd(8'h04, 32'h1, 1'b0, "R3 high level reasserts");
        set_line(1'b0);
        idle(4);
        wr(8'h04, 32'h1);
        idle(2);
        expect_rd(8'h04, 32'h0, 1'b0, "R3 clear once level gone");

        // level low (line is low)
        wr(8'h00, 32'h0);
        idle(3);
        expect_rd(8'h04, 32'h1, 1'b0, "R2 low level sets");
        wr(8'h04, 32'h1);
        idle(1);
        expect_rd(8'h04, 32'h1, 1'b0, "R3 low level reasserts");
        set_line(1'b1);
        idle(4);
        wr(8'h04, 32'h1);
        idle(2);
        expect_rd(8'h04, 32'h0, 1'b0, "R3 low level released");

        // R6 output timing
        wr(8'h00, 32'h3);
        wr(8'h08, 32'h1);
        idle(2);
        expect_rd(8'h08, 32'h1, 1'b0, "R7 enable at 0x08");
        set_line(1'b0);
        idle(4);
        set_line(1'b1);
        expect_rd(8'h04, 32'h0, 1'b0, "R6 t+1");
        expect_rd(8'h04, 32'h0, 1'b0, "R6 t+2");
        expect_rd(8'h04, 32'h1, 1'b0, "R6 pending before output");
        expect_rd(8'h04, 32'h1, 1'b1, "R6 output one clock later");
        wr(8'h08, 32'h0);
        expect_rd(8'h08, 32'h0, 1'b1, "R6 output lags disable");
        expect_rd(8'h08, 32'h0, 1'b0, "R6 output drops");

        // R13 masked window
        wr(8'h04, 32'h1);
        set_line(1'b0);
        idle(4);
        set_line(1'b1);
        idle(4);
        expect_rd(8'h04, 32'h1, 1'b0, "R13 latched while masked");
        wr(8'h08, 32'h1);
        idle(2);
        expect_rd(8'h08, 32'h1, 1'b1, "R13 output on re-enable");

        // R11 unmapped offsets
        wr(8'h08, 32'h0);
        wr(8'h04, 32'h1);
        wr(8'h34, 32'h1);
        wr(8'h0C, 32'h2);
        idle(2);
        expect_rd(8'h08, 32'h0, 1'b0, "R11 R7 write to 0x34 ignored");
        expect_rd(8'h00, 32'h3, 1'b0, "R11 mode unchanged");
        expect_rd(8'h34, 32'h0, 1'b0, "R11 read 0x34 zero");
        expect_rd(8'h0C, 32'h0, 1'b0, "R11 read 0x0C zero");

        // R7 alternate offset instance
        @(negedge clk);
        bus_addr = 8'h34;
        #1 chk_alt(rd_alt, 32'h1, "R7 alt enable at 0x34");
        @(negedge clk);
        bus_addr = 8'h08;
        #1 chk_alt(rd_alt, 32'h0, "R7 alt 0x08 unmapped");
        set_line(1'b0);
        idle(4);
        set_line(1'b1);
        idle(6);
        @(negedge clk);
        #1 chk_alt({31'd0, irq_alt}, 32'h1, "R7 alt output raised");
        chk_alt({31'd0, irq_main}, 32'h0, "R7 main stays masked");

        idle(3);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule